// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-state controller of a small microcontroller. It watches the CPU's wait-for-interrupt strobe and a deep-sleep select bit and decides how far the chip may power down. A light sleep only gates the CPU clock. A deeper request first parks in a holding state until any debugger memory traffic has finished. If a debugger is attached, the block uses an emulated deep sleep that keeps core power and state intact. Otherwise it runs an ordered power-down of the core domain: reset, then isolation, then power removal. The low-frequency RC oscillator can optionally be stopped during that power-down.

When a wake event arrives, the block brings the core back in a fixed order. It raises power, waits for the regulator's power-good input, drops isolation, and keeps the CPU in reset for a fixed number of always-on clocks. Timer-type wake sources are masked when the RC oscillator is stopped and no crystal is present. The debug request lines also serve as wake sources. The source that caused a wake is latched in an always-on register, which software reads and clears after wake.

Top module: `lp_sequencer`

## Requirements
- R1: With the deep-sleep select low, a wait-for-interrupt strobe enters idle (state code 1). In idle, CPU clock enable is 0 and core power is 1. Any set bit of the wake-source vector returns the block to running (code 0) on the next clock. Debug request lines do not wake idle.
- R2: With the deep-sleep select high, a wait-for-interrupt strobe enters the pre-sleep state (code 2). In pre-sleep, core power is 1, isolation is 0 and core reset is 0.
- R3: The block stays in pre-sleep for as long as the debug memory-access request is high. It leaves on the clock after that request clears.
- R4: If the debugger-attached line is high when pre-sleep is left, the block enters emulated sleep (code 3). In emulated sleep, power stays on and reset and isolation stay low. A wake from emulated sleep goes straight to running without any reset.
- R5: With both debug lines low, pre-sleep leads through code 4 (reset asserted), then code 5 (isolation asserted), then code 6 (core power 0), one clock each. In code 6 the RC oscillator enable is 1, unless the oscillator-off input was high when pre-sleep was left (level 2), in which case it is 0.
- R6: In level 2 with the crystal-present flag low, wake bits 1 (sleep timer) and 2 (watchdog) are ignored. With the crystal present, or in level 1, they wake the block. All other wake bits always wake it.
- R7: In levels 1 and 2, either debug line wakes the block. In emulated sleep, the memory-access request wakes it.
- R8: A wake from code 6 moves to code 7. In code 7, core power is 1, RC oscillator enable is 1, and isolation and reset are both 1. The block stays there until power-good is high.
- R9: After power-good, code 8 releases isolation and holds reset for exactly 4 clocks. The block then returns to running with reset released.
- R10: On every wake transition, the wake-reason output loads the effective wake vector. Bits 0..5 are the sources, bit 6 is the memory-access request and bit 7 is debugger-attached. A one-clock clear strobe zeroes the register.
- R11: A wait-for-interrupt strobe while any wake-source bit is already high leaves the block in running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_i | input | 1 | Wait-for-interrupt strobe from the CPU |
| deep_sel_i | input | 1 | Selects deep sleep instead of idle |
| osc_off_i | input | 1 | Stop the RC oscillator in true deep sleep (level 2) |
| xtal_ok_i | input | 1 | Low-frequency crystal clocks the timers |
| dbg_mem_req_i | input | 1 | Debugger requests memory access |
| dbg_attach_i | input | 1 | Debugger is attached |
| wake_src_i | input | 6 | Wake sources: 0 interrupt, 1 sleep timer, 2 watchdog, 3..5 pins |
| pwr_good_i | input | 1 | Core supply has reached regulation |
| reason_clr_i | input | 1 | Clears the wake-reason register |
| core_pwr_en_o | output | 1 | Core domain power enable |
| iso_o | output | 1 | Core-to-always-on isolation |
| core_rst_o | output | 1 | Core reset |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| rc_osc_en_o | output | 1 | RC oscillator enable |
| pwr_state_o | output | 4 | Current power state code |
| wake_reason_o | output | 8 | Latched wake vector |

## Verification
The bench sweeps every wake bit, including both debug lines, across all four combinations of oscillator-off and crystal-present. A design that masks timer sources in the wrong level would either stay asleep when it should wake, or wake from a stopped timer. Two corner cases are targeted directly: idle must not wake on debug lines, and pre-sleep must not leak out while memory access is pending. A design that got either wrong would move state one clock early. The bench counts the clocks of every power-up stage. An off-by-one reset hold, or isolation released before power-good, shows up as a wrong state code or a wrong reset level on a specific clock. The emulated path is checked to never pulse reset. A wrong reason capture or clear shows as a wrong bit pattern after wake.

// File: rtl/lp_seq_pkg.sv
// Package: shared state encoding and wake-source bit positions for the
// low-power sequencer. Assumes the wake vector holds at least three sources.
package lp_seq_pkg;
    localparam int IRQ_IDX = 0;
    localparam int TMR_IDX = 1;
    localparam int WDG_IDX = 2;

    typedef enum logic [3:0] {
        ST_RUN    = 4'd0,
        ST_IDLE   = 4'd1,
        ST_PRE    = 4'd2,
        ST_EMU    = 4'd3,
        ST_PD_RST = 4'd4,
        ST_PD_ISO = 4'd5,
        ST_DEEP   = 4'd6,
        ST_PU_PWR = 4'd7,
        ST_PU_RST = 4'd8
    } lp_state_e;
endpackage

// File: rtl/lp_wake_filter.sv
// Wake filter: builds the effective wake vector for the current sleep context.
// Timer-type sources are masked when the RC oscillator is off and no crystal
// is present; the two debug lines are appended as the top bits when enabled.
// Assumes purely combinational use, with the enables decoded by the caller.
module lp_wake_filter
    import lp_seq_pkg::*;
#(
    parameter int NUM_WAKE = 6
) (
    input  logic [NUM_WAKE-1:0] src_i,
    input  logic                osc_stopped_i,
    input  logic                xtal_ok_i,
    input  logic                mem_en_i,
    input  logic                att_en_i,
    input  logic                dbg_mem_req_i,
    input  logic                dbg_attach_i,
    output logic [NUM_WAKE+1:0] vec_o
);
    logic timer_mask;

    // timers lose their clock only without a crystal in level 2
    assign timer_mask = osc_stopped_i & ~xtal_ok_i;

    for (genvar gi = 0; gi < NUM_WAKE; gi++) begin : g_src
        if (gi == TMR_IDX || gi == WDG_IDX) begin : g_timer
            assign vec_o[gi] = src_i[gi] & ~timer_mask;
        end else begin : g_plain
            assign vec_o[gi] = src_i[gi];
        end
    end

    assign vec_o[NUM_WAKE]   = dbg_mem_req_i & mem_en_i;
    assign vec_o[NUM_WAKE+1] = dbg_attach_i & att_en_i;
endmodule

// File: rtl/lp_wake_reason.sv
// Wake-reason register in the always-on domain: loads the effective wake
// vector on a capture strobe, cleared by a one-cycle clear strobe. Capture
// wins over clear when both occur together.
module lp_wake_reason #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [WIDTH-1:0] vec_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] reason_o
);
    // hold, load or clear the latched reason
    always_ff @(posedge clk) begin
        if (!rst_n)     reason_o <= '0;
        else if (cap_i) reason_o <= vec_i;
        else if (clr_i) reason_o <= '0;
    end

    AST_REASON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> reason_o == $past(vec_i)); // R10
    AST_REASON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !cap_i) |=> reason_o == '0); // R10
endmodule

// File: rtl/lp_sequencer.sv
// Low-power mode sequencer: moves the chip between running, idle, a debug-safe
// pre-sleep hold, emulated deep sleep and true deep sleep (levels 1 and 2),
// with ordered core power-down and power-up. Assumes a free-running always-on
// clock, a single-cycle wfi strobe, and power-good that follows power enable.
module lp_sequencer
    import lp_seq_pkg::*;
#(
    parameter int NUM_WAKE = 6,
    parameter int RST_HOLD = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wfi_i,
    input  logic                deep_sel_i,
    input  logic                osc_off_i,
    input  logic                xtal_ok_i,
    input  logic                dbg_mem_req_i,
    input  logic                dbg_attach_i,
    input  logic [NUM_WAKE-1:0] wake_src_i,
    input  logic                pwr_good_i,
    input  logic                reason_clr_i,
    output logic                core_pwr_en_o,
    output logic                iso_o,
    output logic                core_rst_o,
    output logic                cpu_clk_en_o,
    output logic                rc_osc_en_o,
    output logic [3:0]          pwr_state_o,
    output logic [NUM_WAKE+1:0] wake_reason_o
);
    localparam int VEC_W = NUM_WAKE + 2;
    localparam int CNT_W = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_HOLD - 1);
    localparam logic [NUM_WAKE-1:0] TIMER_BITS =
        (NUM_WAKE'(1) << TMR_IDX) | (NUM_WAKE'(1) << WDG_IDX);

    lp_state_e        state_q, state_d;
    logic             lvl2_q;
    logic [CNT_W-1:0] cnt_q;
    logic [VEC_W-1:0] wake_vec;
    logic             wake_any;
    logic             in_deep, in_emu;
    logic             cap;

    assign in_deep = (state_q == ST_DEEP);
    assign in_emu  = (state_q == ST_EMU);

    lp_wake_filter #(.NUM_WAKE(NUM_WAKE)) u_filter (
        .src_i         (wake_src_i),
        .osc_stopped_i (in_deep & lvl2_q),
        .xtal_ok_i     (xtal_ok_i),
        .mem_en_i      (in_deep | in_emu),
        .att_en_i      (in_deep),
        .dbg_mem_req_i (dbg_mem_req_i),
        .dbg_attach_i  (dbg_attach_i),
        .vec_o         (wake_vec)
    );

    assign wake_any = |wake_vec;

    // next-state decision for the power sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wfi_i && !(|wake_src_i))
                    state_d = deep_sel_i ? ST_PRE : ST_IDLE;
            end
            ST_IDLE:   if (wake_any) state_d = ST_RUN;
            ST_PRE: begin
                if (!dbg_mem_req_i)
                    state_d = dbg_attach_i ? ST_EMU : ST_PD_RST;
            end
            ST_EMU:    if (wake_any) state_d = ST_RUN;
            ST_PD_RST: state_d = ST_PD_ISO;
            ST_PD_ISO: state_d = ST_DEEP;
            ST_DEEP:   if (wake_any) state_d = ST_PU_PWR;
            ST_PU_PWR: if (pwr_good_i) state_d = ST_PU_RST;
            ST_PU_RST: if (cnt_q == CNT_LAST) state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // wake transitions capture the reason
    assign cap = wake_any && (state_q == ST_IDLE || in_emu || in_deep);

    // state, level latch and reset-hold counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            lvl2_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PRE && state_d == ST_PD_RST)
                lvl2_q <= osc_off_i;
            if (state_q == ST_PU_RST) cnt_q <= cnt_q + 1'b1;
            else                      cnt_q <= '0;
        end
    end

    // per-state drive of the power controls
    always_comb begin
        core_pwr_en_o = 1'b1;
        iso_o         = 1'b0;
        core_rst_o    = 1'b0;
        cpu_clk_en_o  = 1'b0;
        rc_osc_en_o   = 1'b1;
        unique case (state_q)
            ST_RUN:    cpu_clk_en_o = 1'b1;
            ST_PD_RST: core_rst_o = 1'b1;
            ST_PD_ISO: begin core_rst_o = 1'b1; iso_o = 1'b1; end
            ST_DEEP: begin
                core_rst_o    = 1'b1;
                iso_o         = 1'b1;
                core_pwr_en_o = 1'b0;
                rc_osc_en_o   = ~lvl2_q;
            end
            ST_PU_PWR: begin core_rst_o = 1'b1; iso_o = 1'b1; end
            ST_PU_RST: core_rst_o = 1'b1;
            default: ;
        endcase
    end

    assign pwr_state_o = state_q;

    lp_wake_reason #(.WIDTH(VEC_W)) u_reason (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .vec_i    (wake_vec),
        .clr_i    (reason_clr_i),
        .reason_o (wake_reason_o)
    );

    AST_IDLE_KEEPS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (core_pwr_en_o && !core_rst_o && !cpu_clk_en_o)); // R1
    AST_PRE_NO_POWERDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE) |-> (core_pwr_en_o && !iso_o && !core_rst_o)); // R2
    AST_PRE_HOLDS_FOR_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE && dbg_mem_req_i) |=> (state_q == ST_PRE)); // R3
    AST_EMU_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMU) |=> (!core_rst_o && core_pwr_en_o)); // R4
    AST_ISO_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iso_o) |-> (core_rst_o && $past(core_rst_o))); // R5
    AST_POWER_OFF_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_pwr_en_o) |-> ($past(iso_o) && iso_o)); // R5
    AST_L2_TIMER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_deep && lvl2_q && !xtal_ok_i && !dbg_mem_req_i && !dbg_attach_i &&
         ((wake_src_i & ~TIMER_BITS) == '0)) |=> (state_q == ST_DEEP)); // R6
    AST_ISO_AFTER_PGOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_o) |-> ($past(pwr_good_i) && core_rst_o)); // R9
    AST_WFI_PENDING_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && (|wake_src_i)) |=> (state_q == ST_RUN)); // R11
endmodule

// File: tb/lp_sequencer_tb.sv
module lp_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wfi = 0, deep_sel = 0, osc_off = 0, xtal_ok = 0;
    logic       dbg_mem = 0, dbg_att = 0, pwr_good = 0, clr = 0;
    logic [5:0] wake_src = '0;
    logic       pwr_en, iso, crst, clk_en, rc_en;
    logic [3:0] st;
    logic [7:0] reason;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    lp_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .deep_sel_i(deep_sel),
        .osc_off_i(osc_off), .xtal_ok_i(xtal_ok), .dbg_mem_req_i(dbg_mem),
        .dbg_attach_i(dbg_att), .wake_src_i(wake_src), .pwr_good_i(pwr_good),
        .reason_clr_i(clr), .core_pwr_en_o(pwr_en), .iso_o(iso),
        .core_rst_o(crst), .cpu_clk_en_o(clk_en), .rc_osc_en_o(rc_en),
        .pwr_state_o(st), .wake_reason_o(reason)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // controls packed as {pwr, iso, rst, clk, rc}
    function automatic int ctl();
        return {pwr_en, iso, crst, clk_en, rc_en};
    endfunction

    task automatic pulse_wfi(input logic deep);
        deep_sel = deep;
        wfi = 1;
        step();
        wfi = 0;
    endtask

    task automatic clear_reason();
        clr = 1;
        step();
        clr = 0;
        chk("R10 reason cleared", reason, 0);
    endtask

    task automatic enter_deep(input logic osc);
        osc_off = osc;
        pulse_wfi(1);
        chk("R2 pre state", st, 2);
        chk("R2 pre controls", ctl(), 5'b10001);
        step();
        chk("R5 reset stage", st, 4);
        chk("R5 reset stage ctl", ctl(), 5'b10101);
        step();
        chk("R5 iso stage", st, 5);
        chk("R5 iso stage ctl", ctl(), 5'b11101);
        step();
        chk("R5 deep state", st, 6);
        chk("R5 deep ctl", ctl(), {4'b0110, ~osc});
    endtask

    task automatic power_up();
        chk("R8 wait-power ctl", ctl(), 5'b11101);
        step();
        chk("R8 holds without power-good", st, 7);
        pwr_good = 1;
        step();
        chk("R9 reset-hold state", st, 8);
        chk("R9 reset-hold ctl", ctl(), 5'b10101);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R9 reset still held", {st, crst}, {4'd8, 1'b1});
        end
        step();
        chk("R9 back to run", st, 0);
        chk("R9 run ctl", ctl(), 5'b10011);
        pwr_good = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1 reset state", st, 0);
        chk("R1 reset ctl", ctl(), 5'b10011);
        chk("R10 reset reason", reason, 0);

        // R11: strobe with a pending source is refused, both modes
        wake_src = 6'b001000;
        pulse_wfi(0);
        chk("R11 idle refused", st, 0);
        pulse_wfi(1);
        chk("R11 deep refused", st, 0);
        wake_src = '0;

        // R1: idle, every source wakes, debug lines do not
        for (int k = 0; k < 6; k++) begin
            pulse_wfi(0);
            chk("R1 idle state", st, 1);
            chk("R1 idle ctl", ctl(), 5'b10001);
            dbg_mem = 1;
            dbg_att = 1;
            step();
            chk("R1 debug ignored in idle", st, 1);
            dbg_mem = 0;
            dbg_att = 0;
            wake_src = 6'(1 << k);
            step();
            wake_src = '0;
            chk("R1 idle wake", st, 0);
            chk("R10 idle reason", reason, 1 << k);
            clear_reason();
        end

        // R3: pre-sleep held by memory request
        dbg_mem = 1;
        pulse_wfi(1);
        for (int i = 0; i < 4; i++) begin
            chk("R3 held in pre", st, 2);
            chk("R2 held ctl", ctl(), 5'b10001);
            step();
        end
        dbg_mem = 0;
        step();
        chk("R3 released to power-down", st, 4);
        step();
        step();
        wake_src = 6'b000001;
        step();
        wake_src = '0;
        chk("R8 wake to power-up", st, 7);
        power_up();
        clear_reason();

        // R4/R7: emulated sleep, timer wake then memory-request wake
        dbg_att = 1;
        osc_off = 1;
        pulse_wfi(1);
        step();
        chk("R4 emulated state", st, 3);
        chk("R4 emulated ctl", ctl(), 5'b10001);
        step();
        chk("R4 attach alone no wake", st, 3);
        wake_src = 6'b000010;
        step();
        wake_src = '0;
        chk("R4 wake straight to run", st, 0);
        chk("R4 no reset on wake", crst, 0);
        chk("R10 emulated reason", reason, 8'h02);
        pulse_wfi(1);
        step();
        dbg_mem = 1;
        step();
        dbg_mem = 0;
        chk("R7 mem request wakes emulated", st, 0);
        chk("R10 mem request reason", reason, 8'h40);
        clear_reason();
        dbg_att = 0;

        // R5-R10 sweep: level x crystal x wake bit
        for (int o = 0; o < 2; o++) begin
            for (int x = 0; x < 2; x++) begin
                for (int k = 0; k < 8; k++) begin
                    bit masked;
                    xtal_ok = x[0];
                    enter_deep(o[0]);
                    masked = (o == 1) && (x == 0) && (k == 1 || k == 2);
                    if (k < 6)       wake_src = 6'(1 << k);
                    else if (k == 6) dbg_mem = 1;
                    else             dbg_att = 1;
                    step();
                    if (masked) begin
                        chk("R6 timer masked in level 2", st, 6);
                        wake_src = wake_src | 6'b000001;
                        step();
                        chk("R6 other source wakes", st, 7);
                        chk("R10 masked reason", reason, 1);
                    end else begin
                        chk("R6/R7 source wakes deep", st, 7);
                        chk("R10 deep reason", reason, 1 << k);
                    end
                    wake_src = '0;
                    dbg_mem = 0;
                    dbg_att = 0;
                    chk("R8 oscillator back on", rc_en, 1);
                    power_up();
                    clear_reason();
                end
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule